// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the read side of a synchronous burst memory. A 16-bit configuration word chooses how a read behaves. In asynchronous mode the data bus follows the address input directly. In synchronous mode a strobe captures the start address on a rising clock edge. The block then counts a programmed number of clocks with its wait indicator held active. After that it delivers one 16-bit word per beat, holding each word for one or two clocks.

The burst address steps upward by one. In wrap mode the low bits roll over inside a 4, 8 or 16 word window and the upper bits stay fixed. In linear or continuous mode the whole address increments. The burst runs until chip enable is released. The output stage can present data on the rising edge, or half a clock later on the falling edge. The storage is a computed model: the word at address A is {A[7:0] XOR 8'h5A, bitwise-NOT A[7:0]}.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the configuration reads 16'h9CC7, the error flag is 0, dq_oe is 0 and wait_out is at its inactive level. In that default the asynchronous mode is selected, the latency is 3, wait is active high, the edge is rising and the burst is continuous.
- R2: A write with legal fields is stored on the next rising edge. Bits 14, 5 and 4 are stored as 0. The field positions are: bit 15 = asynchronous mode (1) or synchronous mode (0); bits 13:11 = latency code; bit 10 = wait polarity (1 = active high); bit 9 = two-clock hold; bit 8 = early wait; bit 7 = linear order; bit 6 = rising edge (1) or falling edge (0); bit 3 = no-wrap; bits 2:0 = burst length code.
- R3: A write is rejected and the stored word is left unchanged if any of these holds: the latency code is outside 2..6, the length code is not 001, 010, 011 or 111, or bit 8 is 1. A rejected write sets cfg_err, which stays at 1 until reset.
- R4: In asynchronous mode with ce_n low, dq_oe is 1, dq_out is the model word at addr_in, and wait_out is inactive.
- R5: In synchronous mode, for latency code L, suppose the address is latched on rising edge k. Then the first word is valid after edge k+L. After edges k through k+L-1, wait_out is active and dq_oe is 0. Words follow the address sequence with no gap and no extra beat.
- R6: Bit 10 selects the wait level. When the bit is 1, active is 1; when it is 0, active is 0. The inactive level is the inverse. Data is never valid while wait is active.
- R7: With bit 9 at 0 each word is shown for one clock. With bit 9 at 1 each word is shown for two clocks.
- R8: With bit 3 at 0 and a length of 4, 8 or 16, the low log2(length) address bits count modulo the length and the upper bits stay fixed.
- R9: With bit 3 at 1, or with length code 111, the address increments through the whole address space, modulo 256.
- R10: With bit 6 at 0 the synchronous outputs change half a clock after the rising edge. 1 ns after edge k+L, wait is still active and dq_oe is 0.
- R11: When ce_n goes high, dq_oe falls at once without waiting for a clock edge. The sequencer is idle from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_value | output | 16 | Stored configuration word |
| cfg_err | output | 1 | Sticky illegal-write flag |
| ce_n | input | 1 | Chip enable, active low |
| addr_stb | input | 1 | Address latch strobe, sampled on the rising edge |
| addr_in | input | AW (8) | Read address |
| dq_out | output | 16 | Read data, 0 when not driven |
| dq_oe | output | 1 | Data bus drive enable |
| wait_out | output | 1 | Wait indicator, programmable polarity |

## Verification
The checks assume four things about the inputs. Configuration is written only while the chip is deselected. addr_stb is raised only with ce_n low. A new configuration never changes mode in the middle of a burst. The reset is applied before the first edge. The stimulus follows these rules: every configuration write happens between bursts with ce_n high, and every burst is opened by a single strobe cycle and closed by ce_n. Rejected writes are issued only while the chip is idle, so the unchanged register is observed directly on cfg_value.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CFG_W  = 16;
    localparam int DATA_W = 16;
    localparam int LAT_W  = 3;

    localparam logic [CFG_W-1:0] CFG_RESET = 16'h9CC7;
    localparam logic [CFG_W-1:0] CFG_KEEP  = 16'hBFCF;

    typedef enum logic [1:0] {ST_IDLE, ST_LAT, ST_DATA} seq_st_e;

    function automatic logic lat_legal(input logic [LAT_W-1:0] c);
        return (c >= 3'd2) && (c <= 3'd6);
    endfunction

    function automatic logic len_legal(input logic [2:0] c);
        return (c == 3'd1) || (c == 3'd2) || (c == 3'd3) || (c == 3'd7);
    endfunction

    function automatic logic [DATA_W-1:0] word_at(input logic [7:0] a);
        return {a ^ 8'h5A, ~a};
    endfunction
endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
    import burst_seq_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_VAL = CFG_RESET
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg_q,
    output logic             err_q
);
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             err;
    } cfg_state_t;

    cfg_state_t r_d, r_q;
    logic       legal;

    always_comb begin
        legal = lat_legal(wr_data[13:11]) && len_legal(wr_data[2:0]) && !wr_data[8];
        r_d   = r_q;
        if (wr_en) begin
            if (legal) r_d.cfg = wr_data & CFG_KEEP;
            else       r_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cfg <= RESET_VAL;
            r_q.err <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_q = r_q.cfg;
    assign err_q = r_q.err;

    p_cfg_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lat_legal(r_q.cfg[13:11]) && len_legal(r_q.cfg[2:0]) && !r_q.cfg[8]);

    p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.err |=> r_q.err);

    p_reject_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !legal) |=> $stable(r_q.cfg));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    input  logic          wrap_en,
    input  logic [2:0]    len_code,
    output logic [AW-1:0] addr_q
);
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct packed {
        logic [AW-1:0] addr;
    } addr_state_t;

    addr_state_t   r_d, r_q;
    logic [AW-1:0] wmask;
    logic [AW-1:0] next_lin;
    logic          wrap_act;

    always_comb begin
        case (len_code)
            3'd1:    wmask = AW'(3);
            3'd2:    wmask = AW'(7);
            3'd3:    wmask = AW'(15);
            default: wmask = '1;
        endcase
        wrap_act = wrap_en && (len_code != 3'd7);
        next_lin = r_q.addr + AW'(1);
        r_d      = r_q;
        if (load) begin
            r_d.addr = load_addr;
        end else if (step) begin
            r_d.addr = wrap_act ? ((r_q.addr & ~wmask) | (next_lin & wmask)) : next_lin;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign addr_q = r_q.addr;

    p_wrap_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && wrap_act) |=>
            ((r_q.addr & ~wmask) == ($past(r_q.addr) & ~$past(wmask))));
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = LAT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_act,
    input  logic             sync_en,
    input  logic             start,
    input  logic [CNT_W-1:0] lat_code,
    input  logic             hold2,
    output logic             load,
    output logic             step,
    output logic             in_lat,
    output logic             in_data
);
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic             hold_left;
    } seq_state_t;

    seq_state_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        load = 1'b0;
        step = 1'b0;
        if (!ce_act || !sync_en) begin
            r_d.st = ST_IDLE;
        end else if (start) begin
            r_d.st  = ST_LAT;
            r_d.cnt = lat_code - CNT_W'(1);
            load    = 1'b1;
        end else begin
            case (r_q.st)
                ST_LAT: begin
                    if (r_q.cnt == '0) begin
                        r_d.st        = ST_DATA;
                        r_d.hold_left = hold2;
                        step          = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt - CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    if (!r_q.hold_left) begin
                        r_d.hold_left = hold2;
                        step          = 1'b1;
                    end else begin
                        r_d.hold_left = 1'b0;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st        <= ST_IDLE;
            r_q.cnt       <= '0;
            r_q.hold_left <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_lat  = (r_q.st == ST_LAT);
    assign in_data = (r_q.st == ST_DATA);

    p_lat_to_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.st == ST_DATA) |-> $past(r_q.st == ST_LAT && r_q.cnt == '0));

    p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_act |=> (r_q.st == ST_IDLE));
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
    import burst_seq_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_value,
    output logic              cfg_err,
    input  logic              ce_n,
    input  logic              addr_stb,
    input  logic [AW-1:0]     addr_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              wait_out
);
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct packed {
        logic [DATA_W-1:0] dq;
    } rise_state_t;

    typedef struct packed {
        logic              dat;
        logic              lat;
        logic [DATA_W-1:0] dq;
    } fall_state_t;

    logic [CFG_W-1:0]  cfg;
    logic              ce_act, async_md, edge_rise, wpol;
    logic              load, step, in_lat, in_data;
    logic [AW-1:0]     addr_q;
    rise_state_t       rise_d, rise_q;
    fall_state_t       fall_d, fall_q;
    logic              sel_dat, sel_lat, wait_act, oe_int;
    logic [DATA_W-1:0] sel_dq, data_int;
    logic              unused_cfg;

    assign ce_act     = !ce_n;
    assign async_md   = cfg[15];
    assign wpol       = cfg[10];
    assign edge_rise  = cfg[6];
    assign unused_cfg = ^{cfg[14], cfg[7], cfg[5:4]};

    burst_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .cfg_q   (cfg),
        .err_q   (cfg_err)
    );

    burst_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_act   (ce_act),
        .sync_en  (!async_md),
        .start    (addr_stb),
        .lat_code (cfg[13:11]),
        .hold2    (cfg[9]),
        .load     (load),
        .step     (step),
        .in_lat   (in_lat),
        .in_data  (in_data)
    );

    burst_addr_gen #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_addr (addr_in),
        .step      (step),
        .wrap_en   (!cfg[3]),
        .len_code  (cfg[2:0]),
        .addr_q    (addr_q)
    );

    always_comb begin
        rise_d = rise_q;
        if (step) rise_d.dq = word_at(addr_q[7:0]);
        fall_d.dat = in_data;
        fall_d.lat = in_lat;
        fall_d.dq  = rise_q.dq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= rise_d;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= fall_d;
    end

    always_comb begin
        sel_dat  = edge_rise ? in_data   : fall_q.dat;
        sel_lat  = edge_rise ? in_lat    : fall_q.lat;
        sel_dq   = edge_rise ? rise_q.dq : fall_q.dq;
        oe_int   = ce_act && (async_md || sel_dat);
        data_int = async_md ? word_at(addr_in[7:0]) : sel_dq;
        wait_act = ce_act && !async_md && sel_lat;
    end

    assign dq_oe     = oe_int;
    assign dq_out    = oe_int ? data_int : '0;
    assign wait_out  = wpol ? wait_act : !wait_act;
    assign cfg_value = cfg;

    p_async_no_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (async_md && ce_act) |-> (wait_out == !wpol));

    p_no_data_in_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_out == wpol) |-> !(dq_oe && !async_md && in_data && edge_rise));
endmodule

// File: tb/sim_burst_read_seq.sv
module sim_burst_read_seq;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n, cfg_we, cfg_err, ce_n, addr_stb, dq_oe, wait_out;
    logic [15:0] cfg_wdata, cfg_value, dq_out;
    logic [7:0]  addr_in;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    bit          mon_en = 1'b0;
    bit          cur_pol = 1'b0;
    logic [15:0] expq[$];

    always #2.5 clk = ~clk;

    burst_read_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_value(cfg_value), .cfg_err(cfg_err), .ce_n(ce_n),
        .addr_stb(addr_stb), .addr_in(addr_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .wait_out(wait_out)
    );

    function automatic logic [15:0] mk_cfg(bit asy, int lat, bit pol, bit hold2,
                                           bit rise, bit nowrap, int len);
        logic [15:0] v;
        v        = '0;
        v[15]    = asy;
        v[13:11] = lat[2:0];
        v[10]    = pol;
        v[9]     = hold2;
        v[7]     = 1'b1;
        v[6]     = rise;
        v[3]     = nowrap;
        v[2:0]   = len[2:0];
        return v;
    endfunction

    function automatic logic [15:0] exp_word(logic [7:0] a);
        return {a ^ 8'h5A, ~a};
    endfunction

    function automatic logic [7:0] exp_addr(logic [7:0] a, int i, bit nowrap, int len);
        logic [7:0] m;
        logic [7:0] s;
        s = a + 8'(i);
        if (len == 7 || nowrap) return s;
        m = (len == 1) ? 8'd3 : (len == 2) ? 8'd7 : 8'd15;
        return (a & ~m) | (s & m);
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: pops one expected word per valid beat
    always @(posedge clk) begin
        #4;
        if (mon_en && dq_oe && wait_out != cur_pol) begin
            if (expq.size() == 0) begin
                check("R5", "extra beat", {16'h0, dq_out}, 32'hFFFF_FFFF);
            end else begin
                check("R5 R7 R8 R9", "burst word", {16'h0, dq_out}, {16'h0, expq.pop_front()});
            end
        end
    end

    task automatic wr_cfg(logic [15:0] v);
        @(posedge clk); #2 cfg_we = 1'b1; cfg_wdata = v;
        @(posedge clk); #2 cfg_we = 1'b0;
    endtask

    task automatic run_burst(int lat, bit pol, bit hold2, bit fall,
                             logic [7:0] a, int n, bit nowrap, int len);
        int reps;
        reps = hold2 ? 2 : 1;
        @(posedge clk); #2 ce_n = 1'b0; addr_stb = 1'b1; addr_in = a;
        @(posedge clk); #2 addr_stb = 1'b0;
        for (int i = 0; i < n; i++)
            for (int h = 0; h < reps; h++)
                expq.push_back(exp_word(exp_addr(a, i, nowrap, len)));
        cur_pol = pol;
        mon_en  = 1'b1;
        #2;
        check("R5 R6", "wait during latency", {31'h0, wait_out}, {31'h0, pol});
        check("R5", "no drive during latency", {31'h0, dq_oe}, 32'h0);
        for (int j = 1; j < lat; j++) begin
            @(posedge clk); #4;
            check("R5 R6", "wait during latency", {31'h0, wait_out}, {31'h0, pol});
            check("R5", "no drive during latency", {31'h0, dq_oe}, 32'h0);
        end
        if (fall) begin
            @(posedge clk); #1;
            check("R10", "falling-edge wait still active", {31'h0, wait_out}, {31'h0, pol});
            check("R10", "falling-edge data not yet driven", {31'h0, dq_oe}, 32'h0);
            repeat (n * reps - 1) @(posedge clk);
        end else begin
            repeat (n * reps) @(posedge clk);
        end
        #4.5 ce_n = 1'b1;
        #0.3;
        check("R11", "drive drops with ce_n", {31'h0, dq_oe}, 32'h0);
        check("R6", "wait inactive after abort", {31'h0, wait_out}, {31'h0, !pol});
        mon_en = 1'b0;
        check("R5", "all beats delivered", expq.size(), 32'h0);
        expq.delete();
        @(posedge clk); #4;
        check("R11", "idle after abort", {31'h0, dq_oe}, 32'h0);
    endtask

    task automatic async_read(logic [7:0] a, bit pol);
        @(posedge clk); #2 ce_n = 1'b0; addr_in = a;
        #1;
        check("R4", "async data", {16'h0, dq_out}, {16'h0, exp_word(a)});
        check("R4", "async drive", {31'h0, dq_oe}, 32'h1);
        check("R4", "async wait inactive", {31'h0, wait_out}, {31'h0, !pol});
        #0.5 ce_n = 1'b1;
    endtask

    initial begin
        logic [15:0] keep;
        logic [15:0] v;
        rst_n = 1'b0; ce_n = 1'b1; addr_stb = 1'b0; cfg_we = 1'b0;
        cfg_wdata = '0; addr_in = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #2;
        check("R1", "reset cfg", {16'h0, cfg_value}, 32'h9CC7);
        check("R1", "reset err", {31'h0, cfg_err}, 32'h0);
        check("R1", "reset oe", {31'h0, dq_oe}, 32'h0);
        check("R1", "reset wait", {31'h0, wait_out}, 32'h0);

        async_read(8'h5C, 1'b1);
        async_read(8'hA3, 1'b1);

        v = mk_cfg(0, 2, 0, 0, 1, 0, 1);
        wr_cfg(v);
        check("R2", "legal write stored", {16'h0, cfg_value}, {16'h0, v});
        run_burst(2, 0, 0, 0, 8'h16, 6, 0, 1);

        wr_cfg(mk_cfg(0, 5, 1, 1, 1, 1, 2));
        run_burst(5, 1, 1, 0, 8'hFE, 10, 1, 2);

        wr_cfg(mk_cfg(0, 3, 0, 0, 1, 0, 3));
        run_burst(3, 0, 0, 0, 8'h2D, 20, 0, 3);

        wr_cfg(mk_cfg(0, 6, 1, 0, 1, 0, 7));
        run_burst(6, 1, 0, 0, 8'h3E, 5, 0, 7);

        wr_cfg(mk_cfg(0, 4, 0, 1, 0, 0, 2));
        run_burst(4, 0, 1, 1, 8'h63, 9, 0, 2);

        keep = cfg_value;
        wr_cfg(mk_cfg(0, 7, 0, 0, 1, 0, 1));
        check("R3", "bad latency rejected", {16'h0, cfg_value}, {16'h0, keep});
        check("R3", "error raised", {31'h0, cfg_err}, 32'h1);
        wr_cfg(mk_cfg(0, 1, 0, 0, 1, 0, 1));
        check("R3", "latency 1 rejected", {16'h0, cfg_value}, {16'h0, keep});
        wr_cfg(mk_cfg(0, 3, 0, 0, 1, 0, 4));
        check("R3", "bad length rejected", {16'h0, cfg_value}, {16'h0, keep});
        wr_cfg(mk_cfg(0, 3, 0, 0, 1, 0, 1) | 16'h0100);
        check("R3", "early wait rejected", {16'h0, cfg_value}, {16'h0, keep});

        v = mk_cfg(1, 3, 0, 0, 1, 0, 7);
        wr_cfg(v | 16'h4030);
        check("R2", "reserved bits cleared", {16'h0, cfg_value}, {16'h0, v});
        check("R3", "error stays set", {31'h0, cfg_err}, 32'h1);
        async_read(8'h81, 1'b0);

        wr_cfg(mk_cfg(0, 2, 1, 0, 1, 0, 1));
        run_burst(2, 1, 0, 0, 8'h47, 4, 0, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule